// File: doc/BRIEF.md
# Station Address Clock-Domain Transfer Register

This block holds one 48-bit station address in the host clock domain and gives a copy of it to a separate line clock domain. The address is kept in two host-side shadow registers: an upper register of 16 bits and a lower register of 32 bits. Each is written through a simple write port with byte enables. Host reads return the shadow contents at once, whether or not the line side has taken the last value yet.

Writes to the shadows do not reach the line side by themselves. A transfer starts only when a write to the lower register enables one particular byte lane. The endianness mode input selects that lane. On such a write the host side flips a request flag. A two-flop synchronizer carries the flag into the line domain. When the line side sees the flag change, it loads all 48 bits from the shadows in a single line cycle and pulses an update-done strobe. The line side returns the flag it has taken to the host through a second two-flop synchronizer. The host side therefore knows when a transfer is still in flight, and it records a sticky overrun when software touches the shadows too early.

Top module: `station_addr_cdc`

## Requirements
- R1: While either reset is asserted, and after it is released, both shadow registers and `addr_o` hold all ones, and `upd_o` and `overrun_o` are 0.
- R2: A write with `wr_upper_i`=1 loads byte lanes 0..1 of `wr_data_i` into the upper shadow where `wr_be_i[1:0]` are set; `wr_be_i[3:2]` and `wr_data_i[31:16]` are ignored. A write with `wr_upper_i`=0 loads each lower-shadow byte whose enable bit is set. `rd_data_o` returns the upper shadow zero-extended in bits [15:0] when `rd_upper_i`=1, and the lower shadow when it is 0. It does so combinationally, from the cycle after the write.
- R3: With `big_endian_i`=0, a lower-register write with `wr_be_i[3]`=1 starts a transfer.
- R4: With `big_endian_i`=1, a lower-register write with `wr_be_i[0]`=1 starts a transfer. A write with only `wr_be_i[3]` set does not start one in this mode.
- R5: Upper-register writes, and lower-register writes that do not enable the trigger lane, leave `addr_o` unchanged and produce no `upd_o` pulse.
- R6: After a transfer starts, `addr_o` becomes {upper shadow, lower shadow}, with the upper shadow in bits [47:32]. This happens at the third line-clock edge at which the host request flag has already changed.
- R7: `upd_o` is high for exactly one line cycle per captured transfer, in the cycle where the new `addr_o` first appears. `addr_o` does not change in any cycle where `upd_o` is low.
- R8: A write to either shadow while a transfer is in flight sets `overrun_o`. A transfer is in flight from the trigger until the line side's acknowledgement has come back through two host flops. `overrun_o` stays set until host reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk_i | input | 1 | Host clock |
| hrst_ni | input | 1 | Host active-low asynchronous reset |
| lclk_i | input | 1 | Line clock |
| lrst_ni | input | 1 | Line active-low asynchronous reset |
| big_endian_i | input | 1 | Trigger lane select: 0 = byte 3, 1 = byte 0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_upper_i | input | 1 | Write target: 1 = upper, 0 = lower |
| wr_be_i | input | 4 | Byte enables |
| wr_data_i | input | 32 | Write data |
| rd_upper_i | input | 1 | Read select: 1 = upper, 0 = lower |
| rd_data_o | output | 32 | Shadow read data |
| overrun_o | output | 1 | Sticky early-write flag |
| addr_o | output | 48 | Line-domain station address |
| upd_o | output | 1 | One-cycle update-done pulse |

## Verification
The bench drives writes that fill in the shadows without enabling the trigger lane. A design that started a transfer on any lower write would then move a half-built address across, and `addr_o` would change too early. The bench switches the endianness mode between triggers and writes the opposite lane in each mode, which exposes a swapped or fixed lane select. A behavioural two-domain model predicts the exact line cycle of each capture, so a missing or extra synchronizer stage shows up as a mismatch in `addr_o` or `upd_o`. Back-to-back triggers test that the overrun flag sets and stays set, and that the upd pulse count matches the number of requests.

// File: rtl/station_addr_pkg.sv
package station_addr_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BUS_B   = BUS_W / BYTE_W;
endpackage

// File: rtl/sa_sync_ff.sv
module sa_sync_ff #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= 1'b0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sa_host_regs.sv
module sa_host_regs
  import station_addr_pkg::*;
#(
  parameter int unsigned HI_W = 16,
  parameter int unsigned LO_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              big_endian_i,
  input  logic              wr_en_i,
  input  logic              wr_upper_i,
  input  logic [BUS_B-1:0]  wr_be_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  input  logic              rd_upper_i,
  input  logic              ack_sync_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [LO_W-1:0]   lo_o,
  output logic              req_o,
  output logic              overrun_o
);
  localparam int unsigned HI_B = HI_W / BYTE_W;
  localparam int unsigned LO_B = LO_W / BYTE_W;

  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            req_q, ovr_q;
  logic            wr_hi, wr_lo, trig, busy;

  assign wr_hi = wr_en_i &&  wr_upper_i;
  assign wr_lo = wr_en_i && !wr_upper_i;
  // lane that commits the address depends on byte order
  assign trig  = wr_lo && (big_endian_i ? wr_be_i[0] : wr_be_i[LO_B-1]);
  assign busy  = req_q != ack_sync_i;

  generate
    for (genvar b = 0; b < HI_B; b++) begin : g_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_q[b*BYTE_W +: BYTE_W] <= '1;
        else if (wr_hi && wr_be_i[b]) hi_q[b*BYTE_W +: BYTE_W] <= wr_data_i[b*BYTE_W +: BYTE_W];
      end
    end
    for (genvar b = 0; b < LO_B; b++) begin : g_lo
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lo_q[b*BYTE_W +: BYTE_W] <= '1;
        else if (wr_lo && wr_be_i[b]) lo_q[b*BYTE_W +: BYTE_W] <= wr_data_i[b*BYTE_W +: BYTE_W];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (trig) req_q <= ~req_q;
      if (wr_en_i && busy) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_upper_i) rd_data_o[HI_W-1:0] = hi_q;
    else            rd_data_o[LO_W-1:0] = lo_q;
  end

  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign req_o     = req_q;
  assign overrun_o = ovr_q;

  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  // R5
  no_trig_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !trig) |=> $stable(req_q));
  // R2
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_hi) |=> $stable(hi_q));
  // R8
  busy_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy) |=> ovr_q);
endmodule

// File: rtl/sa_line_capture.sv
module sa_line_capture #(
  parameter int unsigned HI_W = 16,
  parameter int unsigned LO_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_sync_i,
  input  logic [HI_W-1:0]      hi_i,
  input  logic [LO_W-1:0]      lo_i,
  output logic [HI_W+LO_W-1:0] addr_o,
  output logic                 upd_o,
  output logic                 ack_o
);
  logic                 seen_q, upd_q, edge_det;
  logic [HI_W+LO_W-1:0] addr_q;

  assign edge_det = req_sync_i != seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      upd_q  <= 1'b0;
      addr_q <= '1;
    end else begin
      seen_q <= req_sync_i;
      upd_q  <= edge_det;
      // shadow is quiet here if host kept the spacing
      if (edge_det) addr_q <= {hi_i, lo_i};
    end
  end

  assign addr_o = addr_q;
  assign upd_o  = upd_q;
  assign ack_o  = seen_q;

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(addr_q));
  // R6
  ack_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> (seen_q != $past(seen_q)));
endmodule

// File: rtl/station_addr_cdc.sv
module station_addr_cdc
  import station_addr_pkg::*;
#(
  parameter int unsigned HI_W        = 16,
  parameter int unsigned LO_W        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 hclk_i,
  input  logic                 hrst_ni,
  input  logic                 lclk_i,
  input  logic                 lrst_ni,
  input  logic                 big_endian_i,
  input  logic                 wr_en_i,
  input  logic                 wr_upper_i,
  input  logic [3:0]           wr_be_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 rd_upper_i,
  output logic [31:0]          rd_data_o,
  output logic                 overrun_o,
  output logic [HI_W+LO_W-1:0] addr_o,
  output logic                 upd_o
);
  logic [HI_W-1:0] hi_s;
  logic [LO_W-1:0] lo_s;
  logic req_h, req_l, ack_l, ack_h;

  sa_host_regs #(.HI_W(HI_W), .LO_W(LO_W)) u_host (
    .clk_i(hclk_i), .rst_ni(hrst_ni), .big_endian_i(big_endian_i),
    .wr_en_i(wr_en_i), .wr_upper_i(wr_upper_i), .wr_be_i(wr_be_i),
    .wr_data_i(wr_data_i), .rd_upper_i(rd_upper_i), .ack_sync_i(ack_h),
    .rd_data_o(rd_data_o), .hi_o(hi_s), .lo_o(lo_s), .req_o(req_h),
    .overrun_o(overrun_o)
  );

  sa_sync_ff #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i(lclk_i), .rst_ni(lrst_ni), .d_i(req_h), .q_o(req_l)
  );

  sa_line_capture #(.HI_W(HI_W), .LO_W(LO_W)) u_line (
    .clk_i(lclk_i), .rst_ni(lrst_ni), .req_sync_i(req_l),
    .hi_i(hi_s), .lo_i(lo_s), .addr_o(addr_o), .upd_o(upd_o), .ack_o(ack_l)
  );

  sa_sync_ff #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i(hclk_i), .rst_ni(hrst_ni), .d_i(ack_l), .q_o(ack_h)
  );
endmodule

// File: tb/station_addr_cdc_tb.sv
module station_addr_cdc_tb;
  logic hclk = 1'b0, lclk = 1'b0;
  logic hrst_n = 1'b0, lrst_n = 1'b0;
  logic big_endian = 1'b0, wr_en = 1'b0, wr_upper = 1'b0, rd_upper = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        overrun, upd;
  logic [47:0] addr;

  int checks = 0, errors = 0, upd_cnt = 0;
  bit done = 1'b0;

  always #10 hclk = ~hclk;          // 50 MHz host
  initial begin #1; forever #6 lclk = ~lclk; end

  station_addr_cdc u_dut (
    .hclk_i(hclk), .hrst_ni(hrst_n), .lclk_i(lclk), .lrst_ni(lrst_n),
    .big_endian_i(big_endian), .wr_en_i(wr_en), .wr_upper_i(wr_upper),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_upper_i(rd_upper),
    .rd_data_o(rd_data), .overrun_o(overrun), .addr_o(addr), .upd_o(upd)
  );

  // behavioural model
  logic [15:0] m_hi;  logic [31:0] m_lo;
  bit m_req, m_ovr, m_a1, m_a2;
  bit m_s1, m_s2, m_seen, m_upd;
  logic [47:0] m_addr;

  always @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      m_hi = '1; m_lo = '1; m_req = 0; m_ovr = 0; m_a1 = 0; m_a2 = 0;
    end else begin
      bit busy, trig, seen_now;
      busy = (m_req != m_a2);
      seen_now = m_seen;
      trig = 0;
      if (wr_en) begin
        if (busy) m_ovr = 1;
        for (int b = 0; b < 4; b++) if (wr_be[b]) begin
          if (wr_upper) begin if (b < 2) m_hi[b*8 +: 8] = wr_data[b*8 +: 8]; end
          else m_lo[b*8 +: 8] = wr_data[b*8 +: 8];
        end
        if (!wr_upper) trig = big_endian ? wr_be[0] : wr_be[3];
      end
      if (trig) m_req = !m_req;
      m_a2 = m_a1; m_a1 = seen_now;
    end
  end

  always @(posedge lclk or negedge lrst_n) begin
    if (!lrst_n) begin
      m_s1 = 0; m_s2 = 0; m_seen = 0; m_upd = 0; m_addr = '1;
    end else begin
      m_upd = (m_s2 != m_seen);
      if (m_upd) m_addr = {m_hi, m_lo};
      m_seen = m_s2; m_s2 = m_s1; m_s1 = m_req;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge lclk) if (lrst_n && hrst_n && !done) begin
    if (upd) upd_cnt++;
    chk(addr === m_addr, "R6", addr, m_addr);
    chk(upd === m_upd, "R7", {47'd0, upd}, {47'd0, m_upd});
  end

  always @(negedge hclk) if (hrst_n && !done) begin
    logic [31:0] er;
    er = rd_upper ? {16'h0, m_hi} : m_lo;
    chk(rd_data === er, "R2", {16'h0, rd_data}, {16'h0, er});
    chk(overrun === m_ovr, "R8", {47'd0, overrun}, {47'd0, m_ovr});
  end

  task automatic wr(input bit up, input logic [3:0] be, input logic [31:0] d);
    wr_en = 1; wr_upper = up; wr_be = be; wr_data = d;
    @(posedge hclk); #2;
    wr_en = 0; wr_be = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge hclk);
    #2;
  endtask

  task automatic probe(input string req, input logic [47:0] exp_addr);
    @(negedge hclk);
    chk(addr === exp_addr, req, addr, exp_addr);
    @(posedge hclk); #2;
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #35; hrst_n = 1; lrst_n = 1;
    @(posedge hclk); #2;
    // R1 reset state
    @(negedge hclk);
    chk(addr === '1, "R1", addr, '1);
    chk(upd === 0 && overrun === 0, "R1", {46'd0, upd, overrun}, 48'd0);
    chk(rd_data === 32'hFFFF_FFFF, "R1", {16'h0, rd_data}, 48'h0000_FFFF_FFFF);
    @(posedge hclk); #2;

    // R2 upper write, upper lanes ignored; R5 no transfer
    wr(1, 4'b1111, 32'hAAAA_1234);
    rd_upper = 1;
    @(negedge hclk);
    chk(rd_data === 32'h0000_1234, "R2", {16'h0, rd_data}, 48'h0000_0000_1234);
    @(posedge hclk); #2;
    idle(10);
    probe("R5", 48'hFFFF_FFFF_FFFF);

    // R5 lower write without lane 3 in little-endian mode
    rd_upper = 0;
    wr(0, 4'b0111, 32'h0055_6677);
    idle(10);
    probe("R5", 48'hFFFF_FFFF_FFFF);
    chk(upd_cnt == 0, "R5", upd_cnt, 0);

    // R3 trigger on byte 3
    wr(0, 4'b1000, 32'h8800_0000);
    idle(10);
    probe("R3", 48'h1234_8855_6677);
    chk(upd_cnt == 1, "R7", upd_cnt, 1);

    // R4 big-endian: byte 3 does not trigger, byte 0 does
    big_endian = 1;
    wr(1, 4'b0011, 32'h0000_BEEF);
    wr(0, 4'b1000, 32'h1100_0000);
    idle(10);
    probe("R4", 48'h1234_8855_6677);
    wr(0, 4'b0001, 32'h0000_0022);
    idle(10);
    probe("R4", 48'hBEEF_1155_6622);
    chk(upd_cnt == 2, "R7", upd_cnt, 2);
    chk(overrun === 0, "R8", {47'd0, overrun}, 48'd0);

    // R8 back-to-back triggers
    wr(0, 4'b0001, 32'h0000_0033);
    wr(0, 4'b0001, 32'h0000_0044);
    idle(20);
    chk(overrun === 1, "R8", {47'd0, overrun}, 48'd1);
    probe("R6", 48'hBEEF_1155_6644);
    chk(upd_cnt == 4, "R7", upd_cnt, 4);
    idle(5);
    chk(overrun === 1, "R8", {47'd0, overrun}, 48'd1);

    finish_run();
  end
endmodule